// File: doc/BRIEF.md
# Read Completion Generator with Splitting

This block sits on the egress side of a PCI Express completer. It accepts one decoded memory read request at a time (length, tag, requester ID, traffic class, low address bits, first and last byte enables, a lock flag) together with the outcome of servicing it: unsupported request, completer abort or poisoned data. It then emits the matching completion headers, one per handshake, on a valid/ready stream.

A read whose data fits within the programmed max payload size is answered by a single completion. A longer read is cut into several data completions, sent back to back, each carrying the byte count still outstanding and the low address bits of its first byte. Error outcomes and locked reads collapse to one header with no data. Payload data, address translation, framing and tag allocation are handled elsewhere.

Top module: `rcg_cpl_gen`

## Requirements
- R1: After reset `cpl_valid` is 0 and `req_ready` is 1. A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. Its first completion is valid from the next cycle. `req_ready` stays 0 until the handshake of that request's last completion.
- R2: A request length of 0 means 1024 doublewords. All data completions of one request together return exactly the requested number of doublewords.
- R3: `mps_sel` = n selects a max payload of 128·2^n bytes (32·2^n doublewords). Values above 5 act as 5. Each data completion carries min(remaining, max payload) doublewords. A request that fits gets exactly one completion. A length of 1024 is reported as 0 in `cpl_len`.
- R4: Completions of one request follow back to back while `cpl_ready` is 1. While `cpl_ready` is 0, `cpl_valid` and all header fields hold. `cpl_last` is 1 only on the final completion of a request.
- R5: `cpl_byte_cnt` is 4 × the doublewords still to be returned, including those in the current completion, taken modulo 4096, so 4096 reads as 0.
- R6: `cpl_lower_addr` of the first completion is `req_addr_lo[6:2]` joined with the offset of the lowest set bit of `req_first_be` (00 if none is set). A later completion carries the low 7 bits of (`req_addr_lo` with bits 1:0 cleared) + 4 × the doublewords already sent.
- R7: An unsupported request gives one completion with `cpl_has_data`=0, length 0 and status 3'b001. A completer abort does the same with status 3'b100. Unsupported request wins over completer abort, and both win over the lock flag.
- R8: A locked read with no error gives one completion with `cpl_locked`=1, no data, length 0, status 3'b001 and traffic class 0. Poison is ignored for it.
- R9: With `req_poison` set, `cpl_ep` is 1 on every data completion of the request. `cpl_ep` is never 1 on a completion without data.
- R10: A zero-length read (length 1, both byte enables 0) gives one data completion of length 1 with byte count 1.
- R11: Every completion copies tag, requester ID and traffic class from its request (except R8). `cpl_cid` is 0. A successful completion has status 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_len | input | 10 | Length in doublewords, 0 = 1024 |
| req_addr_lo | input | 7 | Low bits of the request address |
| req_first_be | input | 4 | First doubleword byte enables |
| req_last_be | input | 4 | Last doubleword byte enables |
| req_tag | input | 8 | Request tag |
| req_rid | input | 16 | Requester ID |
| req_tc | input | 3 | Traffic class |
| req_lock | input | 1 | Locked read |
| req_ur | input | 1 | Outcome: unsupported request |
| req_ca | input | 1 | Outcome: completer abort |
| req_poison | input | 1 | Outcome: data poisoned |
| mps_sel | input | 3 | Max payload select, 128·2^n bytes |
| cpl_valid | output | 1 | Completion header present |
| cpl_ready | input | 1 | Downstream takes the header |
| cpl_has_data | output | 1 | Completion carries data |
| cpl_locked | output | 1 | Locked completion type |
| cpl_status | output | 3 | Completion status |
| cpl_len | output | 10 | Length in doublewords, 0 = 1024 |
| cpl_byte_cnt | output | 12 | Bytes remaining, 0 = 4096 |
| cpl_lower_addr | output | 7 | Address of the first byte, low bits |
| cpl_tag | output | 8 | Tag copied from the request |
| cpl_rid | output | 16 | Requester ID copied from the request |
| cpl_tc | output | 3 | Traffic class |
| cpl_cid | output | 16 | Completer ID, always 0 |
| cpl_ep | output | 1 | Poisoned data marker |
| cpl_last | output | 1 | Final completion of the request |

## Verification
The splitting path is driven with lengths just inside and just past one max payload, with a length that splits into unequal pieces, and with the 1024-doubleword encoding at the smallest and the largest payload size. Together these separate an off-by-one in the fit test, a wrong remainder and a wrong byte count. Error and lock outcomes are applied alone and in combination, which exposes any mix-up in their priority. A poisoned multi-piece read and a zero-length read cover the flag and the special length. One run with random backpressure shows whether the header fields hold and whether the order survives stalls.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
   typedef enum logic [1:0] {
      K_DATA = 2'd0,
      K_UR   = 2'd1,
      K_CA   = 2'd2,
      K_LOCK = 2'd3
   } rcg_kind_e;

   localparam logic [2:0] ST_SC = 3'b000;
   localparam logic [2:0] ST_UR = 3'b001;
   localparam logic [2:0] ST_CA = 3'b100;
endpackage

// File: rtl/rcg_classify.sv
module rcg_classify
   import rcg_pkg::*;
#(
   parameter int LEN_W = 10,
   localparam int DW_W = LEN_W + 1
) (
   input  logic [LEN_W-1:0] len,
   input  logic [3:0]       first_be,
   input  logic [3:0]       last_be,
   input  logic             lock,
   input  logic             ur,
   input  logic             ca,
   output rcg_kind_e        kind,
   output logic [DW_W-1:0]  total_dw,
   output logic             zero_len,
   output logic [1:0]       lead
);
   always_comb begin
      if (len == '0) total_dw = DW_W'(1) << LEN_W;
      else           total_dw = {1'b0, len};
   end

   assign zero_len = (len == LEN_W'(1)) && (first_be == 4'h0) && (last_be == 4'h0);

   always_comb begin
      if      (ur)   kind = K_UR;
      else if (ca)   kind = K_CA;
      else if (lock) kind = K_LOCK;
      else           kind = K_DATA;
   end

   always_comb begin
      if      (first_be[0]) lead = 2'd0;
      else if (first_be[1]) lead = 2'd1;
      else if (first_be[2]) lead = 2'd2;
      else if (first_be[3]) lead = 2'd3;
      else                  lead = 2'd0;
   end
endmodule

// File: rtl/rcg_mps_limit.sv
module rcg_mps_limit #(
   parameter int SEL_W       = 3,
   parameter int MAX_SEL     = 5,
   parameter int BASE_DW     = 32,
   parameter bit CLAMP       = 1'b1,
   parameter int DW_W        = 11
) (
   input  logic [SEL_W-1:0] sel,
   output logic [DW_W-1:0]  max_dw
);
   logic [SEL_W-1:0] sel_eff;

   generate
      if (CLAMP) begin : g_clamp
         always_comb begin
            if (sel > SEL_W'(MAX_SEL)) sel_eff = SEL_W'(MAX_SEL);
            else                       sel_eff = sel;
         end
      end else begin : g_pass
         assign sel_eff = sel;
      end
   endgenerate

   always_comb begin
      max_dw = DW_W'(BASE_DW);
      for (int i = 0; i < (1 << SEL_W); i++) begin
         if (sel_eff == SEL_W'(i)) max_dw = DW_W'(BASE_DW) << i;
      end
   end
endmodule

// File: rtl/rcg_split_ctrl.sv
module rcg_split_ctrl
   import rcg_pkg::*;
#(
   parameter int LEN_W = 10,
   parameter int BC_W  = 12,
   parameter int LA_W  = 7,
   parameter int TAG_W = 8,
   parameter int RID_W = 16,
   parameter int TC_W  = 3,
   localparam int DW_W = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  rcg_kind_e        kind_in,
   input  logic [DW_W-1:0]  total_in,
   input  logic             zero_in,
   input  logic [1:0]       lead_in,
   input  logic [LA_W-1:0]  addr_in,
   input  logic [TAG_W-1:0] tag_in,
   input  logic [RID_W-1:0] rid_in,
   input  logic [TC_W-1:0]  tc_in,
   input  logic             ep_in,
   input  logic [DW_W-1:0]  max_in,
   input  logic             out_ready,
   output logic             busy,
   output logic             o_has_data,
   output logic             o_locked,
   output logic [2:0]       o_status,
   output logic [LEN_W-1:0] o_len,
   output logic [BC_W-1:0]  o_bc,
   output logic [LA_W-1:0]  o_la,
   output logic [TAG_W-1:0] o_tag,
   output logic [RID_W-1:0] o_rid,
   output logic [TC_W-1:0]  o_tc,
   output logic             o_ep,
   output logic             o_last
);
   rcg_kind_e        kind_q;
   logic [DW_W-1:0]  rem_q;
   logic [DW_W-1:0]  max_q;
   logic [LA_W-1:0]  la_q;
   logic             first_q;
   logic             zero_q;
   logic [1:0]       lead_q;
   logic [TAG_W-1:0] tag_q;
   logic [RID_W-1:0] rid_q;
   logic [TC_W-1:0]  tc_q;
   logic             ep_q;

   logic [DW_W-1:0]  chunk;
   logic [DW_W+1:0]  chunk_b;
   logic [DW_W+1:0]  rem_b;
   logic             is_data;

   assign is_data = (kind_q == K_DATA);
   assign chunk   = (rem_q < max_q) ? rem_q : max_q;
   assign chunk_b = {chunk, 2'b00};
   assign rem_b   = {rem_q, 2'b00};
   assign o_last  = !is_data || (rem_q <= max_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         kind_q  <= K_DATA;
         rem_q   <= '0;
         max_q   <= '0;
         la_q    <= '0;
         first_q <= 1'b0;
         zero_q  <= 1'b0;
         lead_q  <= '0;
         tag_q   <= '0;
         rid_q   <= '0;
         tc_q    <= '0;
         ep_q    <= 1'b0;
      end else if (start) begin
         busy    <= 1'b1;
         kind_q  <= kind_in;
         rem_q   <= total_in;
         max_q   <= max_in;
         la_q    <= {addr_in[LA_W-1:2], 2'b00};
         first_q <= 1'b1;
         zero_q  <= zero_in;
         lead_q  <= lead_in;
         tag_q   <= tag_in;
         rid_q   <= rid_in;
         tc_q    <= (kind_in == K_LOCK) ? '0 : tc_in;
         ep_q    <= ep_in;
      end else if (busy && out_ready) begin
         if (o_last) begin
            busy <= 1'b0;
         end else begin
            rem_q   <= rem_q - chunk;
            la_q    <= la_q + chunk_b[LA_W-1:0];
            first_q <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (kind_q)
         K_UR:    o_status = ST_UR;
         K_CA:    o_status = ST_CA;
         K_LOCK:  o_status = ST_UR;
         default: o_status = ST_SC;
      endcase
   end

   assign o_has_data = is_data;
   assign o_locked   = (kind_q == K_LOCK);
   assign o_len      = is_data ? chunk[LEN_W-1:0] : '0;
   assign o_bc       = zero_q ? BC_W'(1) : rem_b[BC_W-1:0];
   assign o_la       = first_q ? (la_q | LA_W'(lead_q)) : la_q;
   assign o_tag      = tag_q;
   assign o_rid      = rid_q;
   assign o_tc       = tc_q;
   assign o_ep       = ep_q && is_data;
endmodule

// File: rtl/rcg_cpl_gen.sv
module rcg_cpl_gen
   import rcg_pkg::*;
#(
   parameter int LEN_W     = 10,
   parameter int BC_W      = 12,
   parameter int LA_W      = 7,
   parameter int TAG_W     = 8,
   parameter int RID_W     = 16,
   parameter int TC_W      = 3,
   parameter int MPS_SEL_W = 3,
   parameter int MPS_MAX   = 5,
   parameter int MPS_BASE  = 32,
   parameter bit MPS_CLAMP = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [LEN_W-1:0]     req_len,
   input  logic [LA_W-1:0]      req_addr_lo,
   input  logic [3:0]           req_first_be,
   input  logic [3:0]           req_last_be,
   input  logic [TAG_W-1:0]     req_tag,
   input  logic [RID_W-1:0]     req_rid,
   input  logic [TC_W-1:0]      req_tc,
   input  logic                 req_lock,
   input  logic                 req_ur,
   input  logic                 req_ca,
   input  logic                 req_poison,
   input  logic [MPS_SEL_W-1:0] mps_sel,
   output logic                 cpl_valid,
   input  logic                 cpl_ready,
   output logic                 cpl_has_data,
   output logic                 cpl_locked,
   output logic [2:0]           cpl_status,
   output logic [LEN_W-1:0]     cpl_len,
   output logic [BC_W-1:0]      cpl_byte_cnt,
   output logic [LA_W-1:0]      cpl_lower_addr,
   output logic [TAG_W-1:0]     cpl_tag,
   output logic [RID_W-1:0]     cpl_rid,
   output logic [TC_W-1:0]      cpl_tc,
   output logic [RID_W-1:0]     cpl_cid,
   output logic                 cpl_ep,
   output logic                 cpl_last
);
   localparam int DW_W = LEN_W + 1;

   initial begin
      if (LA_W < 3 || LA_W > DW_W + 2)
         $fatal(1, "rcg_cpl_gen: LA_W out of range");
      if (BC_W > DW_W + 2)
         $fatal(1, "rcg_cpl_gen: BC_W wider than byte span");
      if ((MPS_BASE << MPS_MAX) > (1 << LEN_W))
         $fatal(1, "rcg_cpl_gen: max payload exceeds length range");
   end

   rcg_kind_e       kind;
   logic [DW_W-1:0] total_dw;
   logic [DW_W-1:0] max_dw;
   logic            zero_len;
   logic [1:0]      lead;
   logic            busy;
   logic            accept;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign cpl_valid = busy;
   assign cpl_cid   = '0;

   rcg_classify #(.LEN_W(LEN_W)) u_cls (
      .len      (req_len),
      .first_be (req_first_be),
      .last_be  (req_last_be),
      .lock     (req_lock),
      .ur       (req_ur),
      .ca       (req_ca),
      .kind     (kind),
      .total_dw (total_dw),
      .zero_len (zero_len),
      .lead     (lead)
   );

   rcg_mps_limit #(
      .SEL_W   (MPS_SEL_W),
      .MAX_SEL (MPS_MAX),
      .BASE_DW (MPS_BASE),
      .CLAMP   (MPS_CLAMP),
      .DW_W    (DW_W)
   ) u_mps (
      .sel    (mps_sel),
      .max_dw (max_dw)
   );

   rcg_split_ctrl #(
      .LEN_W (LEN_W),
      .BC_W  (BC_W),
      .LA_W  (LA_W),
      .TAG_W (TAG_W),
      .RID_W (RID_W),
      .TC_W  (TC_W)
   ) u_split (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .kind_in    (kind),
      .total_in   (total_dw),
      .zero_in    (zero_len),
      .lead_in    (lead),
      .addr_in    (req_addr_lo),
      .tag_in     (req_tag),
      .rid_in     (req_rid),
      .tc_in      (req_tc),
      .ep_in      (req_poison),
      .max_in     (max_dw),
      .out_ready  (cpl_ready),
      .busy       (busy),
      .o_has_data (cpl_has_data),
      .o_locked   (cpl_locked),
      .o_status   (cpl_status),
      .o_len      (cpl_len),
      .o_bc       (cpl_byte_cnt),
      .o_la       (cpl_lower_addr),
      .o_tag      (cpl_tag),
      .o_rid      (cpl_rid),
      .o_tc       (cpl_tc),
      .o_ep       (cpl_ep),
      .o_last     (cpl_last)
   );
endmodule

// File: rtl/rcg_cpl_gen_chk.sv
module rcg_cpl_gen_chk #(
   parameter int LEN_W = 10,
   parameter int BC_W  = 12,
   parameter int LA_W  = 7,
   parameter int TC_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             cpl_valid,
   input logic             cpl_ready,
   input logic             cpl_has_data,
   input logic             cpl_locked,
   input logic [2:0]       cpl_status,
   input logic [LEN_W-1:0] cpl_len,
   input logic [BC_W-1:0]  cpl_byte_cnt,
   input logic [LA_W-1:0]  cpl_lower_addr,
   input logic [TC_W-1:0]  cpl_tc,
   input logic             cpl_ep,
   input logic             cpl_last
);
   // R1: no new request while a completion is pending
   a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> !req_ready);

   // R1: accepted request shows a completion in the next cycle
   a_r1_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> cpl_valid);

   // R4: header held under backpressure
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_len) &&
         $stable(cpl_byte_cnt) && $stable(cpl_lower_addr) && $stable(cpl_last) &&
         $stable(cpl_status)));

   // R4: non-final completion is followed at once by another
   a_r4_continue: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_ready && !cpl_last) |=> cpl_valid);

   // R7: no-data completion is single, zero length and not successful
   a_r7_nodata: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !cpl_has_data) |-> (cpl_len == '0 && cpl_last && cpl_status != 3'b000));

   // R8: locked completion form
   a_r8_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_locked) |-> (!cpl_has_data && cpl_status == 3'b001 && cpl_tc == '0));

   // R9: poison only on data completions
   a_r9_ep_data: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_ep) |-> cpl_has_data);
endmodule

bind rcg_cpl_gen rcg_cpl_gen_chk #(
   .LEN_W (LEN_W),
   .BC_W  (BC_W),
   .LA_W  (LA_W),
   .TC_W  (TC_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .cpl_valid      (cpl_valid),
   .cpl_ready      (cpl_ready),
   .cpl_has_data   (cpl_has_data),
   .cpl_locked     (cpl_locked),
   .cpl_status     (cpl_status),
   .cpl_len        (cpl_len),
   .cpl_byte_cnt   (cpl_byte_cnt),
   .cpl_lower_addr (cpl_lower_addr),
   .cpl_tc         (cpl_tc),
   .cpl_ep         (cpl_ep),
   .cpl_last       (cpl_last)
);

// File: tb/test_rcg_cpl_gen.sv
module test_rcg_cpl_gen;
   typedef struct packed {
      logic        has_data;
      logic        locked;
      logic [2:0]  status;
      logic [9:0]  len;
      logic [11:0] bc;
      logic [6:0]  la;
      logic [7:0]  tag;
      logic [15:0] rid;
      logic [2:0]  tc;
      logic [15:0] cid;
      logic        ep;
      logic        last;
   } cpl_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [9:0]  req_len = '0;
   logic [6:0]  req_addr_lo = '0;
   logic [3:0]  req_first_be = '0;
   logic [3:0]  req_last_be = '0;
   logic [7:0]  req_tag = '0;
   logic [15:0] req_rid = '0;
   logic [2:0]  req_tc = '0;
   logic        req_lock = 1'b0;
   logic        req_ur = 1'b0;
   logic        req_ca = 1'b0;
   logic        req_poison = 1'b0;
   logic [2:0]  mps_sel = '0;
   logic        cpl_valid;
   logic        cpl_ready = 1'b1;
   logic        cpl_has_data;
   logic        cpl_locked;
   logic [2:0]  cpl_status;
   logic [9:0]  cpl_len;
   logic [11:0] cpl_byte_cnt;
   logic [6:0]  cpl_lower_addr;
   logic [7:0]  cpl_tag;
   logic [15:0] cpl_rid;
   logic [2:0]  cpl_tc;
   logic [15:0] cpl_cid;
   logic        cpl_ep;
   logic        cpl_last;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    bp_mode  = 1'b0;
   cpl_t  exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   rcg_cpl_gen i_rcg_cpl_gen (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_len(req_len), .req_addr_lo(req_addr_lo),
      .req_first_be(req_first_be), .req_last_be(req_last_be),
      .req_tag(req_tag), .req_rid(req_rid), .req_tc(req_tc),
      .req_lock(req_lock), .req_ur(req_ur), .req_ca(req_ca),
      .req_poison(req_poison), .mps_sel(mps_sel),
      .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
      .cpl_has_data(cpl_has_data), .cpl_locked(cpl_locked),
      .cpl_status(cpl_status), .cpl_len(cpl_len),
      .cpl_byte_cnt(cpl_byte_cnt), .cpl_lower_addr(cpl_lower_addr),
      .cpl_tag(cpl_tag), .cpl_rid(cpl_rid), .cpl_tc(cpl_tc),
      .cpl_cid(cpl_cid), .cpl_ep(cpl_ep), .cpl_last(cpl_last)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [95:0] act, input logic [95:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Scoreboard driver: compute expected completions, then offer the request
   task automatic send(input int len, input int addr, input int fbe, input int lbe,
                       input int tag, input int rid, input int tc,
                       input bit lock, input bit ur, input bit ca, input bit psn,
                       input int mps, input string req);
      int   total, lead, n, maxdw, rem, cur, chunk;
      bit   zl, first;
      cpl_t e;
      total = (len == 0) ? 1024 : len;
      zl    = (len == 1) && (fbe == 0) && (lbe == 0);
      lead  = fbe[0] ? 0 : fbe[1] ? 1 : fbe[2] ? 2 : fbe[3] ? 3 : 0;
      n     = (mps > 5) ? 5 : mps;
      maxdw = 32 << n;
      e.tag = 8'(tag);
      e.rid = 16'(rid);
      e.cid = '0;
      if (ur || ca || lock) begin
         e.has_data = 1'b0;
         e.locked   = lock && !ur && !ca;
         e.status   = ur ? 3'b001 : ca ? 3'b100 : 3'b001;
         e.len      = '0;
         e.bc       = zl ? 12'd1 : 12'((total * 4) % 4096);
         e.la       = 7'(((addr & 7'h7C) | lead));
         e.tc       = e.locked ? 3'd0 : 3'(tc);
         e.ep       = 1'b0;
         e.last     = 1'b1;
         exp_q.push_back(e);
         tag_q.push_back(req);
      end else begin
         rem   = total;
         cur   = addr & 7'h7C;
         first = 1'b1;
         while (rem > 0) begin
            chunk      = (rem < maxdw) ? rem : maxdw;
            e.has_data = 1'b1;
            e.locked   = 1'b0;
            e.status   = 3'b000;
            e.len      = 10'(chunk % 1024);
            e.bc       = zl ? 12'd1 : 12'((rem * 4) % 4096);
            e.la       = first ? 7'(cur | lead) : 7'(cur);
            e.tc       = 3'(tc);
            e.ep       = psn;
            e.last     = (rem <= maxdw);
            exp_q.push_back(e);
            tag_q.push_back(req);
            rem   = rem - chunk;
            cur   = (cur + 4 * chunk) % 128;
            first = 1'b0;
         end
      end
      @(negedge clk);
      req_len      = 10'(len);
      req_addr_lo  = 7'(addr);
      req_first_be = 4'(fbe);
      req_last_be  = 4'(lbe);
      req_tag      = 8'(tag);
      req_rid      = 16'(rid);
      req_tc       = 3'(tc);
      req_lock     = lock;
      req_ur       = ur;
      req_ca       = ca;
      req_poison   = psn;
      mps_sel      = 3'(mps);
      req_valid    = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid    = 1'b0;
   endtask

   // Monitor: set ready for the coming edge, then compare the header taken there
   always @(negedge clk) begin
      if (rst_n) begin
         cpl_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
         if (cpl_valid) begin
            check(!req_ready, "R1", "req_ready while completion pending",
                  96'(req_ready), 96'(0));
            if (cpl_ready) begin
               cpl_t a;
               a = '{cpl_has_data, cpl_locked, cpl_status, cpl_len, cpl_byte_cnt,
                     cpl_lower_addr, cpl_tag, cpl_rid, cpl_tc, cpl_cid, cpl_ep, cpl_last};
               if (exp_q.size() == 0) begin
                  check(1'b0, "R4", "unexpected completion", 96'(a), 96'(0));
               end else begin
                  cpl_t e;
                  string r;
                  e = exp_q.pop_front();
                  r = tag_q.pop_front();
                  check(a == e, r, "completion header", 96'(a), 96'(e));
               end
            end
         end
      end
   end

   initial begin
      #200_000;
      check(1'b0, "R1", "watchdog expired", 96'(0), 96'(1));
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cpl_valid == 1'b0, "R1", "cpl_valid after reset", 96'(cpl_valid), 96'(0));
      check(req_ready == 1'b1, "R1", "req_ready after reset", 96'(req_ready), 96'(1));

      // len, addr, fbe, lbe, tag, rid, tc, lock, ur, ca, poison, mps
      send(4,   'h10, 'hF, 'hF, 'h5A, 'h1234, 5, 0, 0, 0, 0, 0, "R11");
      send(32,  'h00, 'hF, 'hF, 'h01, 'h0001, 0, 0, 0, 0, 0, 0, "R3");
      send(33,  'h00, 'hF, 'hF, 'h02, 'h0002, 1, 0, 0, 0, 0, 0, "R3");
      send(0,   'h00, 'hF, 'hF, 'h03, 'h0003, 2, 0, 0, 0, 0, 7, "R2");
      send(0,   'h40, 'hF, 'hF, 'h04, 'hBEEF, 3, 0, 0, 0, 0, 0, "R2");
      send(300, 'h08, 'hF, 'hF, 'h05, 'h0005, 4, 0, 0, 0, 0, 2, "R5");
      send(40,  'h76, 'hC, 'hF, 'h06, 'h0006, 0, 0, 0, 0, 0, 0, "R6");
      send(8,   'h20, 'hF, 'hF, 'h07, 'h0007, 6, 0, 1, 0, 0, 0, "R7");
      send(8,   'h20, 'hF, 'hF, 'h08, 'h0008, 6, 0, 0, 1, 0, 0, "R7");
      send(8,   'h20, 'hF, 'hF, 'h09, 'h0009, 6, 0, 1, 1, 0, 0, "R7");
      send(8,   'h20, 'hF, 'hF, 'h0A, 'h000A, 6, 1, 1, 0, 0, 0, "R7");
      send(16,  'h04, 'hF, 'hF, 'h0B, 'h000B, 6, 1, 0, 0, 1, 0, "R8");
      send(70,  'h00, 'hF, 'hF, 'h0C, 'h000C, 2, 0, 0, 0, 1, 0, "R9");
      send(1,   'h30, 'h0, 'h0, 'h0D, 'h000D, 1, 0, 0, 0, 0, 0, "R10");
      send(1,   'h30, 'h0, 'h0, 'h0E, 'h000E, 1, 0, 1, 0, 0, 0, "R10");
      bp_mode = 1'b1;
      send(100, 'h14, 'h2, 'hF, 'h0F, 'hA5A5, 7, 0, 0, 0, 0, 0, "R4");
      send(64,  'h00, 'hF, 'hF, 'h10, 'h0010, 3, 0, 0, 0, 1, 1, "R4");

      while (exp_q.size() != 0) @(negedge clk);
      bp_mode = 1'b0;
      repeat (4) @(negedge clk);
      check(cpl_valid == 1'b0, "R4", "no extra completion after last",
            96'(cpl_valid), 96'(0));
      check(req_ready == 1'b1, "R1", "ready after last completion",
            96'(req_ready), 96'(1));
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule